// File: doc/BRIEF.md
# SPI FIFO Status and Request Unit

This block sits beside the transmit and receive FIFOs of an SPI controller. It turns their occupancy counts and a few transfer events into an eight-bit status word, one combined interrupt line and two DMA request lines, one for transmit and one for receive. Software programs an interrupt-enable word and a DMA control word that holds both thresholds. It clears the two sticky event bits by writing ones to the status word. The FIFO storage and the serial shifter live elsewhere and only report counts and strobes to this unit.

Level flags follow the counts combinationally. The overflow and transfer-done bits are registered and sticky. A receive-tail detector lets the receive request fire for a few leftover words that never reach the threshold. It does this once a transfer has finished and the bus has stayed quiet for a programmable number of cycles.

Top module: `spi_fifo_stat_unit`

## Requirements
- R1: Status bit order from bit 0 up: TX empty, TX data request, TX full, RX ready, RX data request, RX full, RX overflow, transfer done. TX empty is 1 when the TX count is 0, and TX full is 1 when the TX count equals the FIFO depth (64).
- R2: TX data request (status bit 1) is 1 exactly when the TX count is less than or equal to the TX threshold.
- R3: RX ready (bit 3) is 1 when the RX count is at least 1. RX full (bit 5) is 1 when the RX count equals 64.
- R4: RX data request (bit 4) is 1 when the RX count is greater than the RX threshold. It is also 1 when the tail condition of R5 holds and the tail enable (DMA control bit 31) is 1.
- R5: The tail condition holds when all of the following are true: a done event has been seen; since then at least 8 clock edges (IDLE_CYC) have passed without tx_pop_i, tx_push_i or rx_push_i; the RX count is between 1 and the RX threshold. Any of those three strobes cancels it until the next done event.
- R6: An overflow event sets status bit 6, and a done event sets status bit 7, on the next clock edge. Each bit then stays set.
- R7: A status-word write (wr_sel_i = 2) with a 1 in bit 6 or bit 7 clears that sticky bit. An event in the same cycle keeps the bit set. Writing the other status bits has no effect.
- R8: irq_o is the OR over i of status bit i AND interrupt-enable bit i. The interrupt-enable word is written with wr_sel_i = 0 and uses bits 7:0.
- R9: The DMA control word is written with wr_sel_i = 1. It holds the TX threshold in bits 5:0, the TX DMA enable in bit 7, the RX threshold in bits 21:16, the RX DMA enable in bit 23, the RX DMA length in bits 29:24 and the tail enable in bit 31. All other bits read back as 0.
- R10: tx_dma_req_o is TX data request AND DMA control bit 7. rx_dma_req_o is RX data request AND DMA control bit 23.
- R11: cnt_word_o carries the TX count in bits 6:0 and the RX count in bits 14:8. All other bits are 0.
- R12: After reset the interrupt-enable word, the DMA control word and both sticky bits are 0, and wr_sel_i = 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_cnt_i | input | 7 | Entries held in the TX FIFO |
| rx_cnt_i | input | 7 | Entries held in the RX FIFO |
| tx_push_i | input | 1 | Software pushed a TX word |
| tx_pop_i | input | 1 | Shifter took a TX word |
| rx_push_i | input | 1 | Shifter stored an RX word |
| ovf_evt_i | input | 1 | RX overflow event |
| done_evt_i | input | 1 | Transfer complete event |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Target: 0 int enable, 1 DMA control, 2 status, 3 none |
| wr_data_i | input | 32 | Write data |
| status_o | output | 8 | Status word |
| int_en_o | output | 8 | Interrupt-enable readback |
| dma_ctrl_o | output | 32 | DMA control readback |
| cnt_word_o | output | 32 | Packed occupancy counts |
| irq_o | output | 1 | Combined interrupt |
| tx_dma_req_o | output | 1 | TX DMA request |
| rx_dma_req_o | output | 1 | RX DMA request |

## Verification
The threshold compares are tried with counts one below, equal to and one above each threshold, and with thresholds of 0 and 63. This separates a "not greater" compare from a "less than" compare. It also tests the empty and full extremes. The tail detector is sampled one edge before and at the end of the idle window, after a cancelling push, with the enable cleared and with an empty RX FIFO, so an off-by-one window or a missing gate shows up. The sticky bits are cleared alone, cleared while a fresh event lands, and hit by writes to the other status bits. Each interrupt enable is set alone, which shows whether enable and flag positions line up.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int STAT_W = 8;
  localparam int THR_W  = 6;

  // status bit positions (order is software visible)
  localparam int B_TXE  = 0;
  localparam int B_TDR  = 1;
  localparam int B_TXF  = 2;
  localparam int B_RXR  = 3;
  localparam int B_RDR  = 4;
  localparam int B_RXF  = 5;
  localparam int B_OVF  = 6;
  localparam int B_DONE = 7;

  // dma control field positions
  localparam int D_TXTHR_LO = 0;
  localparam int D_TXEN     = 7;
  localparam int D_RXTHR_LO = 16;
  localparam int D_RXEN     = 23;
  localparam int D_TAILEN   = 31;
  localparam logic [31:0] DMA_MASK = 32'hBFBF_00BF;

  typedef enum logic [1:0] {
    SEL_IEN  = 2'd0,
    SEL_DMA  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/spi_stat_cfg.sv
module spi_stat_cfg
  import spi_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [31:0]       wr_data_i,
  output logic [STAT_W-1:0] ien_o,
  output logic [31:0]       dma_o
);
  logic [STAT_W-1:0] ien_q;
  logic [31:0]       dma_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      dma_q <= '0;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_IEN) ien_q <= wr_data_i[STAT_W-1:0];
      if (wr_sel_i == SEL_DMA) dma_q <= wr_data_i & DMA_MASK;
    end
  end

  assign ien_o = ien_q;
  assign dma_o = dma_q;

  AST_DMA_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_o & ~DMA_MASK) == '0); // R9
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(dma_o) && $stable(ien_o)); // R12
endmodule

// File: rtl/spi_stat_sticky.sv
module spi_stat_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= 1'b0;
    else if (evt_i) q <= 1'b1;  // event beats clear
    else if (clr_i) q <= 1'b0;
  end

  assign q_o = q;

  AST_STICKY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> q_o); // R6
  AST_STICKY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !evt_i |=> !q_o); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o && !clr_i |=> q_o); // R6
endmodule

// File: rtl/spi_stat_tail.sv
module spi_stat_tail #(
  parameter int CNT_W    = 7,
  parameter int THR_W    = 6,
  parameter int IDLE_CYC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             act_i,
  input  logic             tail_en_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [THR_W-1:0] rx_thr_i,
  output logic             tail_o
);
  localparam int IDLE_W = $clog2(IDLE_CYC + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(IDLE_CYC);

  logic              armed_q;
  logic [IDLE_W-1:0] idle_q;
  logic              below_thr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      idle_q  <= '0;
    end else if (done_i) begin
      armed_q <= 1'b1;
      idle_q  <= '0;
    end else if (act_i) begin
      armed_q <= 1'b0;
      idle_q  <= '0;
    end else if (armed_q && idle_q != IDLE_MAX) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  assign below_thr = (rx_cnt_i != '0) && (rx_cnt_i <= CNT_W'(rx_thr_i));
  assign tail_o    = tail_en_i && armed_q && (idle_q == IDLE_MAX) && below_thr;

  AST_TAIL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_o |-> !$past(act_i) && !$past(done_i)); // R5
  AST_TAIL_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i && !done_i |=> !tail_o); // R5
endmodule

// File: rtl/spi_fifo_stat_unit.sv
module spi_fifo_stat_unit
  import spi_stat_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int IDLE_CYC   = 8,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic             tx_push_i,
  input  logic             tx_pop_i,
  input  logic             rx_push_i,
  input  logic             ovf_evt_i,
  input  logic             done_evt_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [31:0]      wr_data_i,
  output logic [7:0]       status_o,
  output logic [7:0]       int_en_o,
  output logic [31:0]      dma_ctrl_o,
  output logic [31:0]      cnt_word_o,
  output logic             irq_o,
  output logic             tx_dma_req_o,
  output logic             rx_dma_req_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);
  localparam int N_STICKY = 2;

  logic [STAT_W-1:0] ien;
  logic [31:0]       dma;
  logic [THR_W-1:0]  tx_thr, rx_thr;
  logic              tail;
  logic [N_STICKY-1:0] sticky_evt, sticky_clr, sticky_q;
  logic [STAT_W-1:0] stat;
  logic              stat_wr;

  spi_stat_cfg u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .ien_o (ien),
    .dma_o (dma)
  );

  assign tx_thr = dma[D_TXTHR_LO +: THR_W];
  assign rx_thr = dma[D_RXTHR_LO +: THR_W];

  spi_stat_tail #(.CNT_W(CNT_W), .THR_W(THR_W), .IDLE_CYC(IDLE_CYC)) u_tail (
    .clk_i, .rst_ni,
    .done_i    (done_evt_i),
    .act_i     (tx_push_i | tx_pop_i | rx_push_i),
    .tail_en_i (dma[D_TAILEN]),
    .rx_cnt_i  (rx_cnt_i),
    .rx_thr_i  (rx_thr),
    .tail_o    (tail)
  );

  assign stat_wr    = wr_en_i && (wr_sel_i == SEL_STAT);
  assign sticky_evt = {done_evt_i, ovf_evt_i};
  assign sticky_clr = {stat_wr && wr_data_i[B_DONE], stat_wr && wr_data_i[B_OVF]};

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    spi_stat_sticky u_bit (
      .clk_i, .rst_ni,
      .evt_i (sticky_evt[g]),
      .clr_i (sticky_clr[g]),
      .q_o   (sticky_q[g])
    );
  end

  always_comb begin
    stat         = '0;
    stat[B_TXE]  = (tx_cnt_i == '0);
    stat[B_TDR]  = (tx_cnt_i <= CNT_W'(tx_thr));
    stat[B_TXF]  = (tx_cnt_i == FULL_CNT);
    stat[B_RXR]  = (rx_cnt_i != '0);
    stat[B_RDR]  = (rx_cnt_i > CNT_W'(rx_thr)) || tail;
    stat[B_RXF]  = (rx_cnt_i == FULL_CNT);
    stat[B_OVF]  = sticky_q[0];
    stat[B_DONE] = sticky_q[1];
  end

  assign status_o     = stat;
  assign int_en_o     = ien;
  assign dma_ctrl_o   = dma;
  assign irq_o        = |(stat & ien);
  assign tx_dma_req_o = stat[B_TDR] & dma[D_TXEN];
  assign rx_dma_req_o = stat[B_RDR] & dma[D_RXEN];

  always_comb begin
    cnt_word_o            = '0;
    cnt_word_o[0 +: CNT_W] = tx_cnt_i;
    cnt_word_o[8 +: CNT_W] = rx_cnt_i;
  end

  AST_TX_EMPTY_NOT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[B_TXE] && status_o[B_TXF])); // R1
  AST_IRQ_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_q[0] && int_en_o[B_OVF] |-> irq_o); // R8
  AST_RXDMA_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_req_o |-> dma_ctrl_o[D_RXEN] && status_o[B_RDR]); // R10
  AST_TXDMA_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_req_o |-> dma_ctrl_o[D_TXEN]); // R10
endmodule

// File: tb/spi_fifo_stat_unit_bench.sv
module spi_fifo_stat_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  tx_cnt = '0, rx_cnt = '0;
  logic        tx_push = 0, tx_pop = 0, rx_push = 0, ovf_evt = 0, done_evt = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_sel = 2'd3;
  logic [31:0] wr_data = '0;
  logic [7:0]  status, int_en;
  logic [31:0] dma_ctrl, cnt_word;
  logic        irq, tx_req, rx_req;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  spi_fifo_stat_unit u_spi_fifo_stat_unit (
    .clk_i(clk), .rst_ni(rst_n), .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt),
    .tx_push_i(tx_push), .tx_pop_i(tx_pop), .rx_push_i(rx_push),
    .ovf_evt_i(ovf_evt), .done_evt_i(done_evt), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .status_o(status),
    .int_en_o(int_en), .dma_ctrl_o(dma_ctrl), .cnt_word_o(cnt_word),
    .irq_o(irq), .tx_dma_req_o(tx_req), .rx_dma_req_o(rx_req)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic reg_wr(logic [1:0] sel, logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 0; wr_sel = 2'd3; wr_data = '0;
  endtask

  // expected level flags from counts and thresholds
  function automatic logic [7:0] exp_lvl(int txc, int rxc, int txt, int rxt, bit tl);
    logic [7:0] s = '0;
    s[0] = (txc == 0); s[1] = (txc <= txt); s[2] = (txc == 64);
    s[3] = (rxc >= 1); s[4] = (rxc > rxt) || tl; s[5] = (rxc == 64);
    return s;
  endfunction

  task automatic t_reset();
    #1;
    chk("R12 ien after reset", int_en, 0);
    chk("R12 dma after reset", dma_ctrl, 0);
    chk("R12 status after reset", status, 8'h03);
    chk("R12 irq after reset", irq, 0);
    reg_wr(2'd3, 32'hFFFF_FFFF);
    chk("R12 sel3 no write ien", int_en, 0);
    chk("R12 sel3 no write dma", dma_ctrl, 0);
  endtask

  task automatic t_dma_fields();
    reg_wr(2'd1, 32'hFFFF_FFFF);
    chk("R9 reserved bits zero", dma_ctrl, 32'hBFBF_00BF);
    reg_wr(2'd1, (32'd5) | (32'd9 << 16) | (32'd33 << 24));
    chk("R9 field placement", dma_ctrl, 32'h2109_0005);
  endtask

  task automatic t_tx_flags();
    int vals[7] = '{0, 1, 4, 5, 6, 63, 64};
    reg_wr(2'd1, 32'd5);
    rx_cnt = 0;
    foreach (vals[i]) begin
      tx_cnt = 7'(vals[i]); #1;
      chk("R1 R2 tx flags thr5", status[2:0], exp_lvl(vals[i], 0, 5, 0, 0) & 8'h07);
    end
    reg_wr(2'd1, 32'd0);
    tx_cnt = 0; #1; chk("R2 thr0 cnt0", status[1], 1);
    tx_cnt = 1; #1; chk("R2 thr0 cnt1", status[1], 0);
    reg_wr(2'd1, 32'd63);
    tx_cnt = 63; #1; chk("R2 thr63 cnt63", status[1], 1);
    tx_cnt = 64; #1; chk("R1 thr63 cnt64 full", status[2:0], 3'b100);
    tx_cnt = 0;
  endtask

  task automatic t_rx_flags();
    int vals[6] = '{0, 1, 9, 10, 11, 64};
    reg_wr(2'd1, 32'd10 << 16);
    foreach (vals[i]) begin
      rx_cnt = 7'(vals[i]); #1;
      chk("R3 R4 rx flags thr10", status[5:3], 3'(exp_lvl(0, vals[i], 0, 10, 0) >> 3));
    end
    rx_cnt = 0;
  endtask

  task automatic t_dma_req();
    reg_wr(2'd1, 32'd3 | (32'd2 << 16));
    tx_cnt = 2; rx_cnt = 5; #1;
    chk("R10 tx req disabled", tx_req, 0);
    chk("R10 rx req disabled", rx_req, 0);
    reg_wr(2'd1, 32'd3 | (32'd1 << 7) | (32'd2 << 16) | (32'd1 << 23));
    #1;
    chk("R10 tx req enabled", tx_req, 1);
    chk("R10 rx req enabled", rx_req, 1);
    tx_cnt = 4; rx_cnt = 2; #1;
    chk("R10 tx req above thr", tx_req, 0);
    chk("R10 rx req at thr", rx_req, 0);
    tx_cnt = 0; rx_cnt = 0;
  endtask

  task automatic t_tail();
    logic [31:0] cfg = (32'd1 << 31) | (32'd1 << 23) | (32'd4 << 16);
    reg_wr(2'd1, cfg);
    rx_cnt = 3;
    done_evt = 1; tick(); done_evt = 0;
    for (int k = 0; k < 7; k++) tick();
    chk("R5 tail not yet at 7", status[4], 0);
    tick();
    chk("R5 tail at 8 idle", status[4], 1);
    chk("R4 tail drives rx req", rx_req, 1);
    rx_cnt = 0; #1;
    chk("R5 tail needs data", status[4], 0);
    rx_cnt = 4; #1;
    chk("R5 tail at thr", status[4], 1);
    rx_push = 1; tick(); rx_push = 0; #1;
    chk("R5 rx push cancels", status[4], 0);
    done_evt = 1; tick(); done_evt = 0;
    for (int k = 0; k < 4; k++) tick();
    tx_push = 1; tick(); tx_push = 0;
    for (int k = 0; k < 10; k++) tick();
    chk("R5 tx push cancels", status[4], 0);
    reg_wr(2'd1, cfg & 32'h7FFF_FFFF);
    done_evt = 1; tick(); done_evt = 0;
    for (int k = 0; k < 9; k++) tick();
    chk("R4 tail enable off", status[4], 0);
    rx_cnt = 0;
    reg_wr(2'd2, 32'h80); // drop done bit from this test
  endtask

  task automatic t_sticky();
    chk("R6 idle sticky clear", status[7:6], 0);
    ovf_evt = 1; tick(); ovf_evt = 0;
    chk("R6 ovf set", status[6], 1);
    tick(); chk("R6 ovf held", status[6], 1);
    reg_wr(2'd2, 32'h3F);
    chk("R7 other bits no effect", status[7:6], 2'b01);
    reg_wr(2'd2, 32'h40);
    chk("R7 ovf cleared", status[6], 0);
    done_evt = 1; tick(); done_evt = 0;
    chk("R6 done set", status[7], 1);
    done_evt = 1; wr_en = 1; wr_sel = 2'd2; wr_data = 32'h80;
    tick();
    done_evt = 0; wr_en = 0; wr_sel = 2'd3;
    chk("R7 event beats clear", status[7], 1);
    reg_wr(2'd2, 32'hC0);
    chk("R7 both cleared", status[7:6], 0);
    reg_wr(2'd1, 32'h0);
  endtask

  task automatic t_irq();
    reg_wr(2'd1, 32'd2 | (32'd2 << 16));
    tx_cnt = 64; rx_cnt = 0;
    for (int b = 0; b < 8; b++) begin
      reg_wr(2'd0, 32'd1 << b);
      chk("R8 enable readback", int_en, 32'd1 << b);
      chk("R8 single enable", irq, 32'(status[b]));
    end
    ovf_evt = 1; tick(); ovf_evt = 0;
    reg_wr(2'd0, 32'h40);
    chk("R8 ovf irq", irq, 1);
    reg_wr(2'd0, 32'h00);
    chk("R8 all disabled", irq, 0);
    reg_wr(2'd2, 32'h40);
    tx_cnt = 0;
  endtask

  task automatic t_cnt();
    tx_cnt = 7'd64; rx_cnt = 7'd37; #1;
    chk("R11 count word", cnt_word, 32'h0000_2540);
    tx_cnt = 7'd1; rx_cnt = 7'd0; #1;
    chk("R11 count word low", cnt_word, 32'h0000_0001);
    tx_cnt = 0;
  endtask

  initial begin
    #3000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    tick();
    t_reset();
    t_dma_fields();
    t_tx_flags();
    t_rx_flags();
    t_dma_req();
    t_tail();
    t_sticky();
    t_irq();
    t_cnt();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule